// File: doc/BRIEF.md
# Receive Byte Queue with Interrupt and DMA Request Signalling

This block sits between a serial receive shifter and the host bus. Each completed byte from the shifter is pushed into an eight-entry queue that is always in service and has no enable. The host pulls bytes out in the order they arrived. The queue reports its state in three ways:

- a character-available status bit,
- an interrupt request whose fill level is chosen by a mode input,
- an active-low wait/request line that asks a DMA engine to fetch a byte.

Either the hardware reset or a per-channel reset empties the queue. During that reset the block also drives a clear strobe back to the shifter.

The DMA request follows its own rule and ignores the interrupt level. It is asserted while exactly one byte waits. Once more than one byte has piled up, the request is withdrawn, and it comes back only after the queue has drained to empty. A byte that arrives when the queue is full, and no read happens in the same cycle, is lost and sets a sticky overrun flag.

Top module: `rx_byte_queue`

## Requirements
- R1: The queue holds up to 8 bytes. Each accepted read (`rd_en` high while bytes are held) presents the oldest byte on `rd_data` one clock after `rd_en` is sampled, in arrival order.
- R2: `char_avail` is 1 exactly when at least one byte is held, whatever the value of `mode_quad`.
- R3: With `mode_quad` = 0, `int_req` is 1 exactly when one or more bytes are held.
- R4: With `mode_quad` = 1, `int_req` is 1 exactly when four or more bytes are held.
- R5: `wait_req_n` is driven low (request active) only when `dma_en` is 1 and exactly one byte is held, and no more than one byte has been held since the queue was last empty. It stays high whenever `dma_en` is 0.
- R6: After more than one byte has been held, `wait_req_n` stays high until the queue has been empty for at least one clock.
- R7: A push into a full queue with no read in the same cycle drops the byte and sets `overrun`. `overrun` stays set until a reset.
- R8: A read while the queue is empty leaves `rd_data` and the occupancy unchanged.
- R9: `rst` or `chan_rst`, sampled at a clock edge, empties the queue and clears `overrun`, the DMA hold-off and `rd_data` (to 0). `shift_clr` is high during the same cycle that either reset is high.
- R10: A push and a read in the same cycle while the queue is full are both accepted. The count stays at 8 and `overrun` is not set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous hardware reset, active high |
| chan_rst | input | 1 | Synchronous channel reset, active high |
| push_valid | input | 1 | Shifter offers a completed byte |
| push_data | input | 8 | Byte from the shifter |
| rd_en | input | 1 | Host reads the oldest byte |
| mode_quad | input | 1 | Interrupt level: 0 = one byte, 1 = four bytes |
| dma_en | input | 1 | Enables the DMA request on `wait_req_n` |
| rd_data | output | 8 | Last byte read |
| char_avail | output | 1 | At least one byte held |
| int_req | output | 1 | Character-available interrupt request |
| wait_req_n | output | 1 | DMA receive request, active low |
| overrun | output | 1 | Sticky flag: a byte was dropped |
| shift_clr | output | 1 | Clear strobe for the receive shifter |

## Verification
The main test holds the queue at one byte, then pushes it to two and lets it fall back to one. This separates a request line that follows the count from one that holds off until the queue is empty. Filling the queue to eight, adding a ninth byte, and then draining it checks arrival order and overrun. A separate run does a push and a read together while the queue is full, which tells a correct full test apart from one that refuses that push. The fill count is stepped through three, four and five bytes under each setting of `mode_quad` to locate the interrupt level. A long run of random pushes, reads, mode changes and resets is then compared against a queue model on every clock.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // Decisions taken for one clock: what moves in and out of the queue.
    typedef struct packed {
        logic push_ok;
        logic pop_ok;
        logic drop;
    } xfer_t;

    // Fill level at which the character interrupt is raised.
    function automatic int unsigned irq_level(input logic quad, input int unsigned quad_lvl);
        return quad ? quad_lvl : 32'd1;
    endfunction

endpackage

// File: rtl/rxq_occupancy.sv
module rxq_occupancy
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          flush,
    input  logic          push_valid,
    input  logic          rd_en,
    output xfer_t         xfer,
    output logic [CW-1:0] count,
    output logic          overrun
);

    logic is_empty;
    logic is_full;

    assign is_empty = (count == '0);
    assign is_full  = (count == CW'(DEPTH));

    always_comb begin
        xfer.pop_ok  = rd_en && !is_empty;
        xfer.push_ok = push_valid && (!is_full || xfer.pop_ok);
        xfer.drop    = push_valid && !xfer.push_ok;
    end

    always_ff @(posedge clk) begin
        if (flush) begin
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            unique case ({xfer.push_ok, xfer.pop_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
            if (xfer.drop) begin
                overrun <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/rxq_storage.sv
module rxq_storage
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic  clk,
    input  logic  flush,
    input  xfer_t xfer,
    input  byte_t push_data,
    output byte_t rd_data
);

    byte_t         slots [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;

    function automatic logic [PW-1:0] advance(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (xfer.push_ok && !flush) begin
            slots[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (flush) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            rd_data <= '0;
        end else begin
            if (xfer.push_ok) begin
                wr_ptr <= advance(wr_ptr);
            end
            if (xfer.pop_ok) begin
                rd_ptr  <= advance(rd_ptr);
                rd_data <= slots[rd_ptr];
            end
        end
    end

endmodule

// File: rtl/rxq_signals.sv
module rxq_signals
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned QUAD_LEVEL = 4,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          flush,
    input  logic [CW-1:0] count,
    input  logic          mode_quad,
    input  logic          dma_en,
    output logic          char_avail,
    output logic          int_req,
    output logic          wait_req_n
);

    // Set once the queue has held more than one byte, cleared when it is seen empty.
    logic holdoff;

    always_ff @(posedge clk) begin
        if (flush) begin
            holdoff <= 1'b0;
        end else if (count > CW'(1)) begin
            holdoff <= 1'b1;
        end else if (count == '0) begin
            holdoff <= 1'b0;
        end
    end

    assign char_avail = (count != '0);
    assign int_req    = (32'(count) >= irq_level(mode_quad, QUAD_LEVEL));
    assign wait_req_n = !(dma_en && (count == CW'(1)) && !holdoff);

endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned QUAD_LEVEL = 4,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       chan_rst,
    input  logic       push_valid,
    input  logic [7:0] push_data,
    input  logic       rd_en,
    input  logic       mode_quad,
    input  logic       dma_en,
    output logic [7:0] rd_data,
    output logic       char_avail,
    output logic       int_req,
    output logic       wait_req_n,
    output logic       overrun,
    output logic       shift_clr
);

    logic          flush;
    xfer_t         xfer;
    logic [CW-1:0] count;

    assign flush     = rst || chan_rst;
    assign shift_clr = flush;

    rxq_occupancy #(.DEPTH(DEPTH)) u_occ (
        .clk        (clk),
        .flush      (flush),
        .push_valid (push_valid),
        .rd_en      (rd_en),
        .xfer       (xfer),
        .count      (count),
        .overrun    (overrun)
    );

    rxq_storage #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .flush     (flush),
        .xfer      (xfer),
        .push_data (push_data),
        .rd_data   (rd_data)
    );

    rxq_signals #(.DEPTH(DEPTH), .QUAD_LEVEL(QUAD_LEVEL)) u_sig (
        .clk        (clk),
        .flush      (flush),
        .count      (count),
        .mode_quad  (mode_quad),
        .dma_en     (dma_en),
        .char_avail (char_avail),
        .int_req    (int_req),
        .wait_req_n (wait_req_n)
    );

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker (
    input logic       clk,
    input logic       rst,
    input logic       chan_rst,
    input logic       rd_en,
    input logic       mode_quad,
    input logic       dma_en,
    input logic [7:0] rd_data,
    input logic       char_avail,
    input logic       int_req,
    input logic       wait_req_n,
    input logic       overrun,
    input logic       shift_clr
);

    logic flush;
    assign flush = rst || chan_rst;

    // R3: level-one interrupt tracks the status bit
    a_r3_irq_single: assert property (@(posedge clk) disable iff (flush)
        !mode_quad |-> (int_req == char_avail));

    // R4: four-byte interrupt never fires on an empty queue
    a_r4_irq_quad_nonempty: assert property (@(posedge clk) disable iff (flush)
        (mode_quad && int_req) |-> char_avail);

    // R5: request only with DMA on and data present
    a_r5_req_needs_data: assert property (@(posedge clk) disable iff (flush)
        !wait_req_n |-> (dma_en && char_avail));

    // R6: a withdrawn request with data held stays withdrawn next cycle
    a_r6_holdoff_kept: assert property (@(posedge clk) disable iff (flush)
        (dma_en && wait_req_n && char_avail) |=> wait_req_n);

    // R7: overrun is sticky
    a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (flush)
        overrun |=> overrun);

    // R8: reading an empty queue leaves the read data alone
    a_r8_empty_read: assert property (@(posedge clk) disable iff (flush)
        (rd_en && !char_avail) |=> $stable(rd_data));

    // R9: reset empties the queue and clears the flag
    a_r9_flush_clears: assert property (@(posedge clk)
        flush |=> (!char_avail && !overrun && rd_data == 8'h00));

    // R9: shifter clear strobe follows the resets
    a_r9_shift_clr: assert property (@(posedge clk)
        shift_clr == flush);

endmodule

bind rx_byte_queue rxq_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .chan_rst   (chan_rst),
    .rd_en      (rd_en),
    .mode_quad  (mode_quad),
    .dma_en     (dma_en),
    .rd_data    (rd_data),
    .char_avail (char_avail),
    .int_req    (int_req),
    .wait_req_n (wait_req_n),
    .overrun    (overrun),
    .shift_clr  (shift_clr)
);

// File: tb/test_rx_byte_queue.sv
module test_rx_byte_queue;

    localparam int PERIOD = 10;
    localparam int DEPTH  = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       chan_rst = 1'b0;
    logic       push_valid = 1'b0;
    logic [7:0] push_data = 8'h00;
    logic       rd_en = 1'b0;
    logic       mode_quad = 1'b0;
    logic       dma_en = 1'b0;
    logic [7:0] rd_data;
    logic       char_avail;
    logic       int_req;
    logic       wait_req_n;
    logic       overrun;
    logic       shift_clr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    byte unsigned mq[$];
    bit           m_hold = 1'b0;
    byte unsigned m_rd = 8'h00;
    bit           m_ovr = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    rx_byte_queue i_rx_byte_queue (
        .clk        (clk),
        .rst        (rst),
        .chan_rst   (chan_rst),
        .push_valid (push_valid),
        .push_data  (push_data),
        .rd_en      (rd_en),
        .mode_quad  (mode_quad),
        .dma_en     (dma_en),
        .rd_data    (rd_data),
        .char_avail (char_avail),
        .int_req    (int_req),
        .wait_req_n (wait_req_n),
        .overrun    (overrun),
        .shift_clr  (shift_clr)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, actual, expected);
        end
    endtask

    // Model update from the requirements
    always @(posedge clk) begin
        if (rst || chan_rst) begin
            mq.delete();
            m_hold = 1'b0;
            m_rd   = 8'h00;
            m_ovr  = 1'b0;
        end else begin
            bit can_read;
            if (mq.size() > 1) m_hold = 1'b1;
            else if (mq.size() == 0) m_hold = 1'b0;
            can_read = rd_en && (mq.size() > 0);
            if (push_valid && !(mq.size() < DEPTH || can_read)) m_ovr = 1'b1;
            if (can_read) m_rd = mq.pop_front();
            if (push_valid && (mq.size() < DEPTH)) mq.push_back(push_data);
        end
    end

    // Compare every cycle, after the inputs for the coming edge are set
    always @(negedge clk) begin
        #1;
        if (!done) begin
            int n;
            n = mq.size();
            check("R1/R8 rd_data", rd_data, m_rd);
            check("R2 char_avail", char_avail, (n > 0));
            if (mode_quad) check("R4 int_req", int_req, (n >= 4));
            else           check("R3 int_req", int_req, (n >= 1));
            check("R5/R6 wait_req_n", wait_req_n, !(dma_en && n == 1 && !m_hold));
            check("R7 overrun", overrun, m_ovr);
            check("R9 shift_clr", shift_clr, (rst || chan_rst));
        end
    end

    task automatic step(input bit pv, input byte unsigned pd, input bit re);
        @(negedge clk);
        push_valid = pv;
        push_data  = pd;
        rd_en      = re;
    endtask

    task automatic idle();
        step(1'b0, 8'h00, 1'b0);
    endtask

    initial begin
        #(PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // Reset state (R9)
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #2;
        check("R9 reset empty", char_avail, 0);
        check("R9 reset overrun", overrun, 0);
        check("R9 reset rd_data", rd_data, 0);

        // DMA request sequence (R5, R6)
        dma_en = 1'b1;
        step(1, 8'h11, 0);
        idle();
        #2 check("R5 request with one byte", wait_req_n, 0);
        step(1, 8'h22, 0);
        step(0, 0, 1);
        idle();
        #2 check("R6 hold-off after two bytes", wait_req_n, 1);
        step(0, 0, 1);
        idle();
        step(1, 8'h33, 0);
        idle();
        #2 check("R6 request back after empty", wait_req_n, 0);
        dma_en = 1'b0;
        idle();
        #2 check("R5 request off without enable", wait_req_n, 1);
        step(0, 0, 1);
        idle();

        // Fill, overrun, drain in order (R1, R7, R8)
        for (int i = 0; i < DEPTH + 1; i++) step(1, byte'(8'hA0 + i), 0);
        idle();
        #2 check("R7 overrun after ninth push", overrun, 1);
        for (int i = 0; i < DEPTH; i++) begin
            step(0, 0, 1);
            idle();
            #2 check("R1 arrival order", rd_data, 8'hA0 + i);
        end
        step(0, 0, 1);
        idle();
        #2 check("R8 empty read keeps data", rd_data, 8'hA7);

        // Interrupt level sweep (R3, R4)
        chan_rst = 1'b1;
        idle();
        chan_rst = 1'b0;
        for (int m = 0; m < 2; m++) begin
            mode_quad = bit'(m);
            for (int i = 0; i < 5; i++) begin
                step(1, byte'(8'h40 + i), 0);
                idle();
                if (m == 1) check("R4 quad level", int_req, (i + 1) >= 4);
                else        check("R3 single level", int_req, 1);
            end
            for (int i = 0; i < 5; i++) step(0, 0, 1);
            idle();
        end

        // Full queue with push and read together (R10)
        chan_rst = 1'b1;
        idle();
        chan_rst = 1'b0;
        for (int i = 0; i < DEPTH; i++) step(1, byte'(8'h60 + i), 0);
        step(1, 8'h7E, 1);
        idle();
        #2 check("R10 no overrun on simultaneous op", overrun, 0);
        for (int i = 0; i < DEPTH; i++) step(0, 0, 1);
        idle();
        #2 check("R10 accepted byte read last", rd_data, 8'h7E);

        // Random traffic with occasional resets
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            mode_quad = (($urandom_range(0, 63)) == 0) ? ~mode_quad : mode_quad;
            dma_en    = (($urandom_range(0, 63)) == 0) ? ~dma_en : dma_en;
            chan_rst  = (r == 0);
            rst       = (r == 1);
            step(r < 55, byte'($urandom_range(0, 255)), ($urandom_range(0, 99) < 45));
        end
        chan_rst = 1'b0;
        rst = 1'b0;
        idle();
        idle();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule